// File: doc/BRIEF.md
# Serial EEPROM Slave with Supply Write Lockout

This block is the digital core of a 256-byte serial EEPROM that answers as a slave on a two-wire I2C bus. It tracks START and STOP conditions, matches a 7-bit control address, takes a one-byte word address and then either gathers write data into a 16-byte page buffer or returns array contents one byte after another. The bus lines reach it as already-synchronised levels. It pulls SDA down through a single drive-low enable and never drives it high.

A write changes the array only at the STOP that closes the transfer. That STOP also starts a modelled internal program cycle, which runs as a timer of fixed length. For the whole cycle the block ignores the bus, so a master can poll with the control byte until it gets an acknowledge. A supply-supervisor input blocks writes. If it is high at any point between START and STOP, the buffered data is dropped and no program cycle starts.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: Out of reset, `ready_o` is 1 and `sda_low_o` is 0, so SDA is released.
- R2: In the acknowledge slot the block pulls SDA low only for a control byte whose bits 7:4 are 1010 and whose bits 3:1 equal parameter `DEV_SEL`. Bit 0 selects the direction, with 1 meaning read. Any other control byte gets no acknowledge.
- R3: A write transfer carries the control byte, then the word address, then data bytes, then STOP. Each data byte lands at the current address, and the array holds it once the program cycle has finished.
- R4: Successive data bytes advance only the low 4 address bits, which wrap inside the 16-byte page. When more than 16 bytes are sent, the later bytes overwrite the earlier ones in the buffer.
- R5: The program cycle (`ready_o` = 0) starts only at a STOP that follows at least one received data byte. A transfer that carries only a word address starts no cycle.
- R6: `ready_o` stays 0 for exactly `TWR_CYCLES` clock cycles. During that time no control byte is acknowledged and SDA stays released.
- R7: If `inhibit_i` is 1 at any clock between START and STOP of a write, or at the STOP itself, the array is left unchanged and no program cycle starts.
- R8: Reads return the byte at the address pointer and then increment the pointer across all 256 bytes, wrapping from 0xFF to 0x00. A master acknowledge continues the read and a master NACK ends it.
- R9: A repeated START after a word address gives a random read from that address, and the data buffered before it is discarded. A read that follows no word address continues from the pointer left by the last transfer.
- R10: `sda_low_o` changes only after a clock at which SCL was sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level, the wired bus value |
| inhibit_i | input | 1 | Write lockout from the supply supervisor, active high |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| ready_o | output | 1 | 0 while the internal program cycle runs |

## Verification
The bench builds the block with `DEV_SEL` = 3'b010 and `TWR_CYCLES` = 40. With a 40-cycle program window, the exact busy length can be counted cycle by cycle, and the bench can show a control byte going unacknowledged inside the window and acknowledged after it. These small values also make it cheap to sweep all 256 control bytes and to read the whole 256-byte array back, including the pointer wrap past 0xFF.

// File: rtl/eei2c_pkg.sv
// Shared constants and the transfer phase type for the serial EEPROM slave.
package eei2c_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned OFS_W     = 4;
    localparam int unsigned PAGE_LEN  = 1 << OFS_W;
    localparam int unsigned MEM_DEPTH = 1 << ADDR_W;
    localparam int unsigned PAGE_W    = ADDR_W - OFS_W;
    localparam int unsigned BITCNT_W  = 4;
    localparam logic [3:0]  DEV_TYPE  = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_WORD,
        PH_WDAT,
        PH_RDAT
    } phase_e;
endpackage

// File: rtl/eei2c_bus_cond.sv
// Bus condition detector.
// Flags SCL edges and START/STOP conditions by comparing the current bus
// levels with the levels held from the previous clock.
// Assumes scl_i and sda_i are already synchronised to clk.
module eei2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    // Hold the previous bus levels; an idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eei2c_prog_timer.sv
// Internal program cycle timer.
// A start pulse holds busy_o high for exactly CYCLES clocks.
// Assumes start_i arrives only while busy_o is low.
module eei2c_prog_timer #(
    parameter int unsigned CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Load the count on start and run it down to zero while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            remain <= '0;
        end else if (start_i && !busy_o) begin
            busy_o <= 1'b1;
            remain <= CNT_W'(CYCLES - 1);
        end else if (busy_o) begin
            if (remain == '0) busy_o <= 1'b0;
            else remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/eei2c_mem.sv
// Storage array for the EEPROM.
// 256 bytes, reset to the erased value 0xFF. The read port is asynchronous.
// Writing a page commits every masked byte of that page in one clock.
module eei2c_mem
    import eei2c_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [BYTE_W-1:0]                rd_data,
    input  logic                             wr_en,
    input  logic [PAGE_W-1:0]                wr_page,
    input  logic [PAGE_LEN-1:0]              wr_mask,
    input  logic [PAGE_LEN-1:0][BYTE_W-1:0]  wr_data
);
    logic [BYTE_W-1:0] cells [MEM_DEPTH];

    // Erase on reset; otherwise commit the masked bytes of one page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < MEM_DEPTH; a++) cells[a] <= '1;
        end else if (wr_en) begin
            for (int o = 0; o < PAGE_LEN; o++)
                if (wr_mask[o]) cells[{wr_page, OFS_W'(o)}] <= wr_data[o];
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eeprom_i2c_slave.sv
// Serial EEPROM slave (top).
// Decodes I2C transfers: control byte match, word address, page-buffered
// writes and sequential reads. A write commits at STOP and starts the program
// timer, during which the bus is ignored. inhibit_i anywhere from START to
// STOP discards the write. Assumes synchronised bus inputs and a clock well
// above the SCL rate (each SCL level lasts at least two clocks).
module eeprom_i2c_slave
    import eei2c_pkg::*;
#(
    parameter logic [2:0]  DEV_SEL    = 3'b000,
    parameter int unsigned TWR_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic inhibit_i,
    output logic sda_low_o,
    output logic ready_o
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic busy, commit;
    phase_e phase;
    logic [BITCNT_W-1:0] bit_cnt;
    logic in_ack, master_ack_n, drive_q;
    logic [BYTE_W-1:0] shift_q, rd_byte, mem_rd;
    logic [ADDR_W-1:0] addr_ptr;
    logic [OFS_W-1:0] ofs;
    logic [PAGE_LEN-1:0][BYTE_W-1:0] page_buf;
    logic [PAGE_LEN-1:0] page_mask;
    logic wr_pend, inh_seen;

    eei2c_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(bus_start), .stop_o(bus_stop)
    );

    eei2c_prog_timer #(.CYCLES(TWR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(commit), .busy_o(busy)
    );

    eei2c_mem u_mem (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr_ptr), .rd_data(mem_rd),
        .wr_en(commit), .wr_page(addr_ptr[ADDR_W-1:OFS_W]),
        .wr_mask(page_mask), .wr_data(page_buf)
    );

    assign ofs    = addr_ptr[OFS_W-1:0];
    assign commit = bus_stop && !busy && wr_pend && !inhibit_i && !inh_seen;

    // Transfer sequencer: bit shifting, acknowledge slots, buffering, read-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_IDLE;
            bit_cnt      <= '0;
            in_ack       <= 1'b0;
            master_ack_n <= 1'b1;
            drive_q      <= 1'b0;
            shift_q      <= '0;
            rd_byte      <= '0;
            addr_ptr     <= '0;
            page_buf     <= '0;
            page_mask    <= '0;
            wr_pend      <= 1'b0;
            inh_seen     <= 1'b0;
        end else if (busy) begin
            phase     <= PH_IDLE;
            in_ack    <= 1'b0;
            bit_cnt   <= '0;
            drive_q   <= 1'b0;
            page_mask <= '0;
            wr_pend   <= 1'b0;
        end else if (bus_start) begin
            phase     <= PH_CTRL;
            bit_cnt   <= '0;
            in_ack    <= 1'b0;
            drive_q   <= 1'b0;
            page_mask <= '0;
            wr_pend   <= 1'b0;
            inh_seen  <= inhibit_i;
        end else if (bus_stop) begin
            phase     <= PH_IDLE;
            in_ack    <= 1'b0;
            drive_q   <= 1'b0;
            page_mask <= '0;
            wr_pend   <= 1'b0;
        end else begin
            if (inhibit_i) inh_seen <= 1'b1;
            if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (in_ack) begin
                        master_ack_n <= sda_i;
                    end else if (bit_cnt < LAST_BIT) begin
                        shift_q <= {shift_q[BYTE_W-2:0], sda_i};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end else if (scl_fall) begin
                    if (!in_ack && bit_cnt == LAST_BIT) begin
                        in_ack <= 1'b1;
                        case (phase)
                            PH_CTRL: begin
                                if (shift_q[7:1] == {DEV_TYPE, DEV_SEL}) drive_q <= 1'b1;
                                else phase <= PH_IDLE;
                            end
                            PH_WORD: begin
                                drive_q  <= 1'b1;
                                addr_ptr <= shift_q;
                            end
                            PH_WDAT: begin
                                drive_q                  <= 1'b1;
                                page_buf[ofs]            <= shift_q;
                                page_mask[ofs]           <= 1'b1;
                                wr_pend                  <= 1'b1;
                                addr_ptr[OFS_W-1:0]      <= ofs + OFS_W'(1);
                            end
                            default: drive_q <= 1'b0;
                        endcase
                    end else if (in_ack) begin
                        in_ack  <= 1'b0;
                        bit_cnt <= '0;
                        drive_q <= 1'b0;
                        case (phase)
                            PH_CTRL: begin
                                if (shift_q[0]) begin
                                    phase    <= PH_RDAT;
                                    rd_byte  <= mem_rd;
                                    addr_ptr <= addr_ptr + 1'b1;
                                    drive_q  <= ~mem_rd[BYTE_W-1];
                                end else begin
                                    phase <= PH_WORD;
                                end
                            end
                            PH_WORD: phase <= PH_WDAT;
                            PH_RDAT: begin
                                if (!master_ack_n) begin
                                    rd_byte  <= mem_rd;
                                    addr_ptr <= addr_ptr + 1'b1;
                                    drive_q  <= ~mem_rd[BYTE_W-1];
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            default: drive_q <= 1'b0;
                        endcase
                    end else if (phase == PH_RDAT) begin
                        drive_q <= ~rd_byte[~bit_cnt[2:0]];
                    end
                end
            end
        end
    end

    assign sda_low_o = drive_q;
    assign ready_o   = ~busy;
endmodule

// File: rtl/eei2c_checker.sv
// Protocol checker for eeprom_i2c_slave, attached through bind.
// Observes only the top-level ports.
module eei2c_checker #(
    parameter int unsigned TWR_CYCLES = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic inhibit_i,
    input logic sda_low_o,
    input logic ready_o
);
    int unsigned low_run;

    // Length of the current run of cycles with ready_o low.
    always_ff @(posedge clk) begin
        if (!rst_n) low_run <= 0;
        else if (!ready_o) low_run <= low_run + 1;
        else low_run <= 0;
    end

    // R6: bus released throughout the program cycle
    p_release_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> !sda_low_o);

    // R6: program cycle lasts exactly TWR_CYCLES
    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (low_run == TWR_CYCLES));

    // R5: program cycle begins only at a STOP
    p_busy_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> ($past(scl_i) && $past(scl_i, 2) && $past(sda_i) && !$past(sda_i, 2)));

    // R7: no program cycle starts under inhibit
    p_no_commit_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> !$past(inhibit_i));

    // R10: SDA drive moves only while SCL is low
    p_sda_on_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low_o) |-> !$past(scl_i));
endmodule

bind eeprom_i2c_slave eei2c_checker #(.TWR_CYCLES(TWR_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .inhibit_i(inhibit_i), .sda_low_o(sda_low_o), .ready_o(ready_o)
);

// File: tb/sim_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module sim_eeprom_i2c_slave;
    localparam int TWR = 40;
    localparam logic [2:0] SEL = 3'b010;
    localparam int H = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, inhibit = 1'b0;
    logic sda_low, ready;
    logic sda_line;
    int tests = 0, fails = 0;
    int r10_bad = 0;
    logic [7:0] mdl [256];

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_low;

    eeprom_i2c_slave #(.DEV_SEL(SEL), .TWR_CYCLES(TWR)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .inhibit_i(inhibit), .sda_low_o(sda_low), .ready_o(ready)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic s, input logic d);
        @(negedge clk);
        scl_m = s;
        sda_m = d;
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        put(0, 1); put(1, 1); put(1, 0); put(0, 0);
    endtask

    task automatic bus_stop();
        put(0, 0); put(1, 0); put(1, 1);
    endtask

    // STOP, then count the cycles with ready low
    task automatic stop_count(output int n);
        put(0, 0); put(1, 0);
        @(negedge clk);
        sda_m = 1'b1;
        n = 0;
        for (int i = 0; i < TWR + 20; i++) begin
            @(negedge clk);
            if (!ready) n++;
            else if (n > 0) break;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            put(0, b[i]); put(1, b[i]); put(0, b[i]);
        end
        put(0, 1); put(1, 1);
        ack = ~sda_line;
        put(0, 1);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        put(0, 1);
        for (int i = 7; i >= 0; i--) begin
            put(1, 1);
            b[i] = sda_line;
            put(0, 1);
        end
        put(0, nack); put(1, nack); put(0, nack); put(0, 1);
    endtask

    // R10 monitor: sda drive must not move while SCL is high
    logic prev_low = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst_n && sda_low !== prev_low && scl_m) r10_bad++;
        prev_low = sda_low;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        int n;
        logic [7:0] cw, cr;
        cw = {4'b1010, SEL, 1'b0};
        cr = {4'b1010, SEL, 1'b1};
        for (int a = 0; a < 256; a++) mdl[a] = 8'hFF;

        repeat (5) @(negedge clk);
        check("R1 ready after reset", int'(ready), 1);
        check("R1 sda released after reset", int'(sda_low), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2: sweep every control byte
        for (int c = 0; c < 256; c++) begin
            bus_start();
            send_byte(8'(c), ack);
            check("R2 control byte ack", int'(ack),
                  int'(c[7:1] == {4'b1010, SEL}));
            if (ack && c[0]) recv_byte(1'b1, rb);
            bus_stop();
        end

        // R3/R6: byte write, then poll during and after the program cycle
        bus_start(); send_byte(cw, ack); send_byte(8'h36, ack); send_byte(8'hC3, ack);
        check("R3 data byte ack", int'(ack), 1);
        bus_stop();
        mdl[8'h36] = 8'hC3;
        bus_start(); send_byte(cw, ack);
        check("R6 no ack while busy", int'(ack), 0);
        bus_stop();
        repeat (TWR + 10) @(negedge clk);
        bus_start(); send_byte(cw, ack);
        check("R6 ack after program cycle", int'(ack), 1);
        bus_stop();

        // R5/R6: exact busy length on a byte write
        bus_start(); send_byte(cw, ack); send_byte(8'h35, ack); send_byte(8'h5A, ack);
        stop_count(n);
        check("R6 busy length", n, TWR);
        mdl[8'h35] = 8'h5A;

        // R5: word address only, no program cycle
        bus_start(); send_byte(cw, ack); send_byte(8'h20, ack);
        stop_count(n);
        check("R5 no cycle without data", n, 0);

        // R4: 20-byte page write from 0x4C wraps inside page 0x40
        bus_start(); send_byte(cw, ack); send_byte(8'h4C, ack);
        for (int k = 0; k < 20; k++) begin
            send_byte(8'(8'h10 + k), ack);
            mdl[{4'h4, 4'(4'hC + k)}] = 8'(8'h10 + k);
        end
        stop_count(n);
        check("R4 page write busy", n, TWR);

        // R7: inhibit pulse mid-transfer
        bus_start(); send_byte(cw, ack); send_byte(8'h80, ack);
        inhibit = 1'b1;
        send_byte(8'h77, ack);
        inhibit = 1'b0;
        stop_count(n);
        check("R7 pulse blocks cycle", n, 0);
        // R7: inhibit held across the whole write
        inhibit = 1'b1;
        bus_start(); send_byte(cw, ack); send_byte(8'h81, ack); send_byte(8'h66, ack);
        stop_count(n);
        check("R7 held inhibit blocks cycle", n, 0);
        inhibit = 1'b0;

        // R9: repeated START discards buffered write, reads next address
        bus_start(); send_byte(cw, ack); send_byte(8'h90, ack); send_byte(8'h11, ack);
        bus_start(); send_byte(cr, ack);
        recv_byte(1'b1, rb);
        bus_stop();
        check("R9 read after repeated start", int'(rb), int'(mdl[8'h91]));
        check("R9 no busy after discard", int'(ready), 1);

        // R8/R3/R4/R9: random read from 0, 257 bytes sequential
        bus_start(); send_byte(cw, ack); send_byte(8'h00, ack);
        bus_start(); send_byte(cr, ack);
        for (int a = 0; a < 257; a++) begin
            recv_byte(a == 256, rb);
            check("R8 sequential read byte", int'(rb), int'(mdl[a % 256]));
        end
        bus_stop();

        // R9: current address read continues at pointer 0x01
        bus_start(); send_byte(cr, ack);
        recv_byte(1'b1, rb);
        bus_stop();
        check("R9 current address read", int'(rb), int'(mdl[1]));

        check("R10 sda moves only with SCL low", r10_bad, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule